// File: doc/BRIEF.md
# Asynchronous 8/9-Bit UART Core

This block is a full-duplex asynchronous serial port with an independent transmitter and receiver. Three framed modes are offered: an 8-bit frame timed by an external rate tick, a 9-bit frame timed by a fixed division of the core clock, and a 9-bit frame timed by the external rate tick. In every mode the line idles high. A frame is a low start bit, then the data bits least significant first, then an optional ninth bit, then a high stop bit. The external tick and the fixed divider both produce a tick at 16 times the bit rate. The receiver uses it to find the middle of each bit, and the transmitter uses it to step from one bit to the next.

The host starts a transmission by writing a byte. In the 9-bit modes the ninth bit is taken from a host input at the same moment. The transmitter raises its flag when it drives the stop bit. The receiver starts on a falling edge of the line, but only while reception is enabled. It commits a frame only if the receive flag is still clear and the multiprocessor filter lets the frame through. A frame that fails either test is discarded, and the received data stays as it was. The host clears each flag with its own clear input.

Top module: `uart_core`

## Requirements
- R1: After reset, txd is 1, tx_flag and rx_flag are 0, and rx_data and rx_bit9 are 0.
- R2: With mode 2'b01, a write sends 10 bits: 0, then wr_data bit 0 up to bit 7, then 1.
- R3: With mode 2'b10 or 2'b11, a write sends 11 bits: 0, then wr_data bit 0 up to bit 7, then the tx_bit9 value taken at the write, then 1.
- R4: With mode 2'b10, one bit lasts 64 clocks when rate_dbl is 0 and 32 clocks when it is 1. With mode 2'b01 or 2'b11, one bit lasts 16 ovf_tick pulses.
- R5: tx_flag rises in the cycle the stop bit is driven onto txd. It is still 0 during the bit before the stop bit, and it stays 1 until tx_flag_clr is pulsed.
- R6: A write that arrives while a frame is being sent is ignored. The frame in progress is unchanged and no second frame follows it.
- R7: With mode 2'b01 and rx_en at 1, a received frame sets rx_flag, puts its byte in rx_data, and puts its stop bit value in rx_bit9.
- R8: With mode 2'b10 or 2'b11, a received frame puts its ninth bit in rx_bit9 and its byte in rx_data.
- R9: While rx_en is 0, a frame on rxd leaves rx_flag, rx_data and rx_bit9 unchanged.
- R10: A frame that completes while rx_flag is 1 is dropped. rx_data and rx_bit9 keep the earlier frame.
- R11: With mp_filter at 1, a frame is dropped when its filter bit is 0 and accepted when it is 1. The filter bit is the stop bit in mode 2'b01 and the ninth bit in the 9-bit modes.
- R12: A low pulse on rxd that has ended by the middle of the start bit is ignored as a false start. A frame that follows it is received normally.
- R13: With mode 2'b00, writes send nothing, txd stays 1, and frames on rxd are not received.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| mode | input | 2 | Mode code: 00 off, 01 8-bit external rate, 10 9-bit fixed rate, 11 9-bit external rate |
| rate_dbl | input | 1 | Doubles the fixed rate in mode 10 |
| ovf_tick | input | 1 | One-cycle pulse at 16 times the bit rate, used in modes 01 and 11 |
| rx_en | input | 1 | Allows the receiver to start on a falling edge |
| mp_filter | input | 1 | Multiprocessor filter enable |
| wr_en | input | 1 | Writes a byte and starts a transmission |
| wr_data | input | 8 | Byte to send |
| tx_bit9 | input | 1 | Ninth bit to send in the 9-bit modes |
| tx_flag_clr | input | 1 | Clears tx_flag |
| rx_flag_clr | input | 1 | Clears rx_flag |
| rx_data | output | 8 | Last accepted byte |
| rx_bit9 | output | 1 | Stop bit (mode 01) or ninth bit (9-bit modes) of the last accepted frame |
| tx_flag | output | 1 | Set when the stop bit is driven |
| rx_flag | output | 1 | Set when a frame is accepted |
| rxd | input | 1 | Serial input |
| txd | output | 1 | Serial output |

## Verification
The assertions assume that mode and rate_dbl change only while both directions are idle, and that ovf_tick is a single-cycle pulse. They also assume that frames arrive on rxd at the bit rate the receiver is set to. The stimulus changes mode and rate only between frames, after the stop bit has ended, and it drives ovf_tick as a one-clock pulse every third clock. Every serial frame it sends uses the same bit length in clocks that the bench expects the block to use in that mode.

// File: rtl/uart_pkg.sv
package uart_pkg;

  typedef enum logic [1:0] {
    MD_OFF    = 2'b00,
    MD_B8_EXT = 2'b01,
    MD_B9_FIX = 2'b10,
    MD_B9_EXT = 2'b11
  } uart_mode_e;

  typedef enum logic [1:0] {
    RX_IDLE  = 2'b00,
    RX_START = 2'b01,
    RX_BITS  = 2'b10
  } rx_state_e;

  // any non-zero mode code turns the port on
  function automatic logic mode_on(input logic [1:0] m);
    return m != MD_OFF;
  endfunction

  // 9-bit frame in the upper two codes
  function automatic logic is_nine(input logic [1:0] m);
    return m[1];
  endfunction

  // external tick drives the odd codes
  function automatic logic ext_rate(input logic [1:0] m);
    return m[0];
  endfunction

  // clocks per oversample tick in the fixed mode
  function automatic int unsigned fix_os_period(input int unsigned per, input logic dbl);
    return dbl ? per / 2 : per;
  endfunction

  // start + data + optional ninth + stop
  function automatic int unsigned frame_bits(input logic nine, input int unsigned dw);
    return dw + 2 + (nine ? 1 : 0);
  endfunction

  // commit rule: flag clear and filter passed
  function automatic logic frame_accept(input logic flag_now, input logic filt, input logic key);
    return !flag_now && (!filt || key);
  endfunction

endpackage

// File: rtl/uart_rate.sv
module uart_rate
  import uart_pkg::*;
#(
  parameter int OVS     = 16,
  parameter int FIX_DIV = 64
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] mode,
  input  logic       rate_dbl,
  input  logic       ovf_tick,
  output logic       os_tick
);
  localparam int PER = FIX_DIV / OVS;
  localparam int CW  = $clog2(PER + 1);

  logic [CW-1:0] cnt;
  logic [CW-1:0] lim_m1;
  logic          fixed_on;
  logic          fix_tick;

  assign fixed_on = (mode == MD_B9_FIX);
  assign lim_m1   = CW'(fix_os_period(PER, rate_dbl) - 1);
  assign fix_tick = fixed_on && (cnt >= lim_m1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         cnt <= '0;
    else if (!fixed_on) cnt <= '0;
    else if (fix_tick)  cnt <= '0;
    else                cnt <= cnt + 1'b1;
  end

  assign os_tick = fix_tick || (ext_rate(mode) && ovf_tick);
endmodule

// File: rtl/uart_tx.sv
module uart_tx
  import uart_pkg::*;
#(
  parameter int DW  = 8,
  parameter int OVS = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [1:0]    mode,
  input  logic          os_tick,
  input  logic          wr_en,
  input  logic [DW-1:0] wr_data,
  input  logic          tx_bit9,
  output logic          txd,
  output logic          tx_active,
  output logic          tx_load,
  output logic          tx_stop
);
  localparam int FW  = DW + 3;
  localparam int PW  = $clog2(OVS);
  localparam int BCW = $clog2(FW + 1);
  localparam logic [PW-1:0]  OS_LAST = PW'(OVS - 1);
  localparam logic [BCW-1:0] ONE_LEFT = BCW'(1);

  logic [PW-1:0]  pcnt;
  logic [FW-1:0]  sh;
  logic [BCW-1:0] left;
  logic           txd_q;
  logic           act_q;
  logic           bnd;

  assign bnd       = os_tick && (pcnt == OS_LAST);
  assign tx_load   = wr_en && !act_q && mode_on(mode);
  assign tx_stop   = bnd && act_q && (left == ONE_LEFT);
  assign txd       = txd_q;
  assign tx_active = act_q;

  // free-running bit-boundary prescaler
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       pcnt <= '0;
    else if (os_tick) pcnt <= (pcnt == OS_LAST) ? '0 : pcnt + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh    <= '1;
      left  <= '0;
      txd_q <= 1'b1;
      act_q <= 1'b0;
    end else if (tx_load) begin
      sh    <= {1'b1, (is_nine(mode) ? tx_bit9 : 1'b1), wr_data, 1'b0};
      left  <= BCW'(frame_bits(is_nine(mode), DW));
      act_q <= 1'b1;
    end else if (bnd && act_q) begin
      if (left == '0) begin
        act_q <= 1'b0;
      end else begin
        txd_q <= sh[0];
        sh    <= {1'b1, sh[FW-1:1]};
        left  <= left - 1'b1;
      end
    end
  end
endmodule

// File: rtl/uart_rx.sv
module uart_rx
  import uart_pkg::*;
#(
  parameter int DW  = 8,
  parameter int OVS = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [1:0]    mode,
  input  logic          os_tick,
  input  logic          rx_en,
  input  logic          mp_filter,
  input  logic          flag_now,
  input  logic          rxd,
  output logic          rx_commit,
  output logic          rx_drop,
  output logic [DW-1:0] rx_byte,
  output logic          rx_key
);
  localparam int PW  = $clog2(OVS);
  localparam int BCW = $clog2(DW + 3);
  localparam logic [PW-1:0]  OS_LAST = PW'(OVS - 1);
  localparam logic [PW-1:0]  OS_MID  = PW'(OVS / 2 - 1);
  localparam logic [BCW-1:0] DW_C    = BCW'(DW);

  rx_state_e      st;
  logic [2:0]     sync;
  logic           s_cur;
  logic           fall;
  logic [PW-1:0]  cnt;
  logic [BCW-1:0] idx;
  logic [BCW-1:0] last_idx;
  logic [DW-1:0]  dat;
  logic           ninth;
  logic           rx_final;
  logic           ok;

  assign s_cur    = sync[1];
  assign fall     = sync[2] && !sync[1];
  assign last_idx = is_nine(mode) ? DW_C + 1'b1 : DW_C;
  assign rx_final = (st == RX_BITS) && os_tick && (cnt == OS_LAST) && (idx == last_idx);
  assign rx_key   = is_nine(mode) ? ninth : s_cur;
  assign ok       = frame_accept(flag_now, mp_filter, rx_key);
  assign rx_commit = rx_final && ok;
  assign rx_drop   = rx_final && !ok;
  assign rx_byte   = dat;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync <= 3'b111;
    else        sync <= {sync[1:0], rxd};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st    <= RX_IDLE;
      cnt   <= '0;
      idx   <= '0;
      dat   <= '0;
      ninth <= 1'b0;
    end else if (!mode_on(mode)) begin
      st <= RX_IDLE;
    end else begin
      case (st)
        RX_IDLE: if (fall && rx_en) begin
          st  <= RX_START;
          cnt <= '0;
        end
        RX_START: if (os_tick) begin
          if (cnt == OS_MID) begin
            st  <= s_cur ? RX_IDLE : RX_BITS;   // high at mid-start: false start
            cnt <= '0;
            idx <= '0;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        RX_BITS: if (os_tick) begin
          if (cnt == OS_LAST) begin
            cnt <= '0;
            idx <= idx + 1'b1;
            if (idx < DW_C)       dat   <= {s_cur, dat[DW-1:1]};
            else if (idx == DW_C) ninth <= s_cur;
            if (idx == last_idx)  st    <= RX_IDLE;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        default: st <= RX_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/uart_core.sv
module uart_core
  import uart_pkg::*;
#(
  parameter int DW      = 8,
  parameter int OVS     = 16,
  parameter int FIX_DIV = 64
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [1:0]    mode,
  input  logic          rate_dbl,
  input  logic          ovf_tick,
  input  logic          rx_en,
  input  logic          mp_filter,
  input  logic          wr_en,
  input  logic [DW-1:0] wr_data,
  input  logic          tx_bit9,
  input  logic          tx_flag_clr,
  input  logic          rx_flag_clr,
  output logic [DW-1:0] rx_data,
  output logic          rx_bit9,
  output logic          tx_flag,
  output logic          rx_flag,
  input  logic          rxd,
  output logic          txd
);
  logic          os_tick;
  logic          tx_active;
  logic          tx_load;
  logic          tx_stop;
  logic          rx_commit;
  logic          rx_drop;
  logic [DW-1:0] rx_byte;
  logic          rx_key;

  uart_rate #(.OVS(OVS), .FIX_DIV(FIX_DIV)) u_rate (
    .clk(clk), .rst_n(rst_n), .mode(mode), .rate_dbl(rate_dbl),
    .ovf_tick(ovf_tick), .os_tick(os_tick)
  );

  uart_tx #(.DW(DW), .OVS(OVS)) u_tx (
    .clk(clk), .rst_n(rst_n), .mode(mode), .os_tick(os_tick),
    .wr_en(wr_en), .wr_data(wr_data), .tx_bit9(tx_bit9),
    .txd(txd), .tx_active(tx_active), .tx_load(tx_load), .tx_stop(tx_stop)
  );

  uart_rx #(.DW(DW), .OVS(OVS)) u_rx (
    .clk(clk), .rst_n(rst_n), .mode(mode), .os_tick(os_tick),
    .rx_en(rx_en), .mp_filter(mp_filter), .flag_now(rx_flag), .rxd(rxd),
    .rx_commit(rx_commit), .rx_drop(rx_drop), .rx_byte(rx_byte), .rx_key(rx_key)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           tx_flag <= 1'b0;
    else if (tx_stop)     tx_flag <= 1'b1;
    else if (tx_flag_clr) tx_flag <= 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_flag <= 1'b0;
      rx_data <= '0;
      rx_bit9 <= 1'b0;
    end else if (rx_commit) begin
      rx_flag <= 1'b1;
      rx_data <= rx_byte;
      rx_bit9 <= rx_key;
    end else if (rx_flag_clr) begin
      rx_flag <= 1'b0;
    end
  end
endmodule

// File: rtl/uart_core_chk.sv
module uart_core_chk #(
  parameter int DW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic [1:0]    mode,
  input logic          os_tick,
  input logic          txd,
  input logic          tx_active,
  input logic          tx_load,
  input logic          tx_flag,
  input logic          tx_flag_clr,
  input logic          rx_flag,
  input logic          rx_flag_clr,
  input logic          rx_commit,
  input logic          rx_drop,
  input logic [DW-1:0] rx_data,
  input logic          rx_bit9
);
  AST_OFF_NO_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'b00) |-> !os_tick) else $error("off mode ticked"); // R13
  AST_OFF_NO_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'b00) |-> !tx_load) else $error("off mode loaded"); // R13
  AST_IDLE_LINE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_active |-> txd) else $error("line low while idle"); // R2
  AST_BUSY_NO_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    tx_active |-> !tx_load) else $error("load while busy"); // R6
  AST_TI_ON_STOP: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tx_flag) |-> txd) else $error("tx flag without stop"); // R5
  AST_TI_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_flag && !tx_flag_clr) |=> tx_flag) else $error("tx flag lost"); // R5
  AST_RI_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rx_flag) |-> $past(rx_commit)) else $error("rx flag without commit"); // R7
  AST_RI_HOLDS_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_flag && !rx_flag_clr) |=> ($stable(rx_data) && $stable(rx_bit9))) else $error("data overwritten"); // R10
  AST_DROP_NO_EFFECT: assert property (@(posedge clk) disable iff (!rst_n)
    rx_drop |=> ($stable(rx_data) && $stable(rx_bit9) && !$rose(rx_flag))) else $error("dropped frame stored"); // R11
endmodule

bind uart_core uart_core_chk #(.DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .mode(mode), .os_tick(os_tick), .txd(txd),
  .tx_active(tx_active), .tx_load(tx_load), .tx_flag(tx_flag),
  .tx_flag_clr(tx_flag_clr), .rx_flag(rx_flag), .rx_flag_clr(rx_flag_clr),
  .rx_commit(rx_commit), .rx_drop(rx_drop), .rx_data(rx_data), .rx_bit9(rx_bit9)
);

// File: tb/sim_uart_core.sv
`timescale 1ns/1ps
module sim_uart_core;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] mode = 2'b00;
  logic       rate_dbl = 1'b0;
  logic       ovf_tick = 1'b0;
  logic       rx_en = 1'b0;
  logic       mp_filter = 1'b0;
  logic       wr_en = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic       tx_bit9 = 1'b0;
  logic       tx_flag_clr = 1'b0;
  logic       rx_flag_clr = 1'b0;
  logic [7:0] rx_data;
  logic       rx_bit9;
  logic       tx_flag;
  logic       rx_flag;
  logic       rxd = 1'b1;
  logic       txd;

  int total = 0;
  int bad = 0;
  logic [7:0] last_byte = 8'h00;
  logic       last_b9 = 1'b0;

  always #2 clk = ~clk;

  uart_core u0 (
    .clk(clk), .rst_n(rst_n), .mode(mode), .rate_dbl(rate_dbl), .ovf_tick(ovf_tick),
    .rx_en(rx_en), .mp_filter(mp_filter), .wr_en(wr_en), .wr_data(wr_data),
    .tx_bit9(tx_bit9), .tx_flag_clr(tx_flag_clr), .rx_flag_clr(rx_flag_clr),
    .rx_data(rx_data), .rx_bit9(rx_bit9), .tx_flag(tx_flag), .rx_flag(rx_flag),
    .rxd(rxd), .txd(txd)
  );

  // external rate: one-clock pulse every third clock, so a bit is 48 clocks
  initial begin
    forever begin
      repeat (2) @(negedge clk);
      ovf_tick = 1'b1;
      @(negedge clk);
      ovf_tick = 1'b0;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog: actual=expired expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  task automatic chk(input string rq, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
    end
  endtask

  task automatic hwrite(input logic [7:0] d, input logic b9);
    @(negedge clk);
    wr_data = d; tx_bit9 = b9; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic wait_start();
    int guard = 0;
    while (txd !== 1'b0 && guard < 5000) begin
      @(negedge clk);
      guard++;
    end
  endtask

  task automatic clear_tx();
    @(negedge clk); tx_flag_clr = 1'b1;
    @(negedge clk); tx_flag_clr = 1'b0;
    chk("R5 clear", int'(tx_flag), 0);
  endtask

  task automatic clear_rx();
    @(negedge clk); rx_flag_clr = 1'b1;
    @(negedge clk); rx_flag_clr = 1'b0;
  endtask

  // sample an outgoing frame at mid-bit points
  task automatic tx_frame(input logic [7:0] d, input logic b9, input logic nine,
                          input int bp, input string rq, input logic inject);
    hwrite(d, b9);
    wait_start();
    repeat (bp / 2) @(negedge clk);
    chk(rq, int'(txd), 0);
    for (int i = 0; i < 8; i++) begin
      if (inject && i == 3) begin
        wr_data = ~d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
        repeat (bp - 1) @(negedge clk);
      end else begin
        repeat (bp) @(negedge clk);
      end
      chk(rq, int'(txd), int'(d[i]));
    end
    if (nine) begin
      repeat (bp) @(negedge clk);
      chk(rq, int'(txd), int'(b9));
    end
    chk("R5 before stop", int'(tx_flag), 0);
    repeat (bp) @(negedge clk);
    chk(rq, int'(txd), 1);
    chk("R5 at stop", int'(tx_flag), 1);
    repeat (bp) @(negedge clk);
    chk("R5 held", int'(tx_flag), 1);
    clear_tx();
  endtask

  // length of the initial low run for an all-zero byte with ninth bit 0
  task automatic low_run(input int exp, input string rq);
    int n = 0;
    hwrite(8'h00, 1'b0);
    wait_start();
    while (txd == 1'b0 && n < 3000) begin
      @(negedge clk);
      n++;
    end
    chk(rq, n, exp);
    repeat (exp / 8) @(negedge clk);
    clear_tx();
  endtask

  task automatic rx_send(input logic [7:0] d, input logic nine, input logic b9,
                         input logic stopv, input int bp);
    rxd = 1'b0;
    repeat (bp) @(negedge clk);
    for (int i = 0; i < 8; i++) begin
      rxd = d[i];
      repeat (bp) @(negedge clk);
    end
    if (nine) begin
      rxd = b9;
      repeat (bp) @(negedge clk);
    end
    rxd = stopv;
    repeat (bp) @(negedge clk);
    rxd = 1'b1;
    repeat (bp) @(negedge clk);
  endtask

  task automatic rx_expect_take(input string rq, input logic [7:0] d, input logic b8);
    chk(rq, int'(rx_flag), 1);
    chk(rq, int'(rx_data), int'(d));
    chk(rq, int'(rx_bit9), int'(b8));
    last_byte = d; last_b9 = b8;
    clear_rx();
  endtask

  task automatic rx_expect_drop(input string rq);
    chk(rq, int'(rx_flag), 0);
    chk(rq, int'(rx_data), int'(last_byte));
    chk(rq, int'(rx_bit9), int'(last_b9));
  endtask

  initial begin
    repeat (5) @(negedge clk);
    chk("R1 txd", int'(txd), 1);
    chk("R1 tx_flag", int'(tx_flag), 0);
    chk("R1 rx_flag", int'(rx_flag), 0);
    chk("R1 rx_data", int'(rx_data), 0);
    chk("R1 rx_bit9", int'(rx_bit9), 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    rx_en = 1'b1;

    // R13: off mode
    begin
      int lows = 0;
      hwrite(8'h00, 1'b0);
      for (int i = 0; i < 800; i++) begin
        @(negedge clk);
        if (txd == 1'b0) lows++;
      end
      chk("R13 txd", lows, 0);
      rx_send(8'h3C, 1'b0, 1'b0, 1'b1, 32);
      rx_expect_drop("R13 rx");
      chk("R13 tx_flag", int'(tx_flag), 0);
    end

    // R4: bit lengths
    mode = 2'b10; rate_dbl = 1'b0;
    low_run(640, "R4 fixed x1");
    rate_dbl = 1'b1;
    low_run(320, "R4 fixed x2");
    mode = 2'b11;
    low_run(480, "R4 ext 9-bit");
    mode = 2'b01;
    low_run(432, "R4 ext 8-bit");

    // R3 / R8 sweep in fixed double rate
    mode = 2'b10; rate_dbl = 1'b1;
    for (int k = 0; k < 18; k++) begin
      logic [7:0] d = 8'(k * 15);
      tx_frame(d, d[0] ^ 1'b1, 1'b1, 32, "R3", 1'b0);
      rx_send(d, 1'b1, d[1], 1'b1, 32);
      rx_expect_take("R8", d, d[1]);
    end

    // R2 / R7 sweep in external 8-bit mode
    mode = 2'b01;
    for (int k = 0; k < 9; k++) begin
      logic [7:0] d = 8'(k * 31) ^ 8'hA5;
      tx_frame(d, 1'b0, 1'b0, 48, "R2", 1'b0);
      rx_send(d, 1'b0, 1'b0, 1'b1, 48);
      rx_expect_take("R7", d, 1'b1);
    end
    rx_send(8'h81, 1'b0, 1'b0, 1'b0, 48);
    rx_expect_take("R7 stop 0", 8'h81, 1'b0);

    // R6: write during a frame
    begin
      int lows = 0;
      tx_frame(8'h96, 1'b0, 1'b0, 48, "R6 frame", 1'b1);
      for (int i = 0; i < 144; i++) begin
        @(negedge clk);
        if (txd == 1'b0) lows++;
      end
      chk("R6 no second frame", lows, 0);
    end

    // R10: flag still set
    rx_send(8'h5A, 1'b0, 1'b0, 1'b1, 48);
    chk("R10 first", int'(rx_data), 'h5A);
    last_byte = 8'h5A; last_b9 = 1'b1;
    rx_send(8'hC3, 1'b0, 1'b0, 1'b0, 48);
    chk("R10 flag", int'(rx_flag), 1);
    chk("R10 data", int'(rx_data), 'h5A);
    chk("R10 bit9", int'(rx_bit9), 1);
    clear_rx();

    // R11: filter in 8-bit mode
    mp_filter = 1'b1;
    rx_send(8'h11, 1'b0, 1'b0, 1'b0, 48);
    rx_expect_drop("R11 stop 0");
    rx_send(8'h22, 1'b0, 1'b0, 1'b1, 48);
    rx_expect_take("R11 stop 1", 8'h22, 1'b1);
    // R11: filter in 9-bit mode
    mode = 2'b11;
    rx_send(8'h33, 1'b1, 1'b0, 1'b1, 48);
    rx_expect_drop("R11 ninth 0");
    rx_send(8'h44, 1'b1, 1'b1, 1'b1, 48);
    rx_expect_take("R11 ninth 1", 8'h44, 1'b1);
    mp_filter = 1'b0;

    // R9: receiver disabled
    rx_en = 1'b0;
    rx_send(8'h77, 1'b1, 1'b0, 1'b1, 48);
    rx_expect_drop("R9");
    rx_en = 1'b1;

    // R12: false start then a real frame
    mode = 2'b10; rate_dbl = 1'b1;
    rxd = 1'b0;
    repeat (6) @(negedge clk);
    rxd = 1'b1;
    repeat (64) @(negedge clk);
    rx_expect_drop("R12 glitch");
    rx_send(8'hE7, 1'b1, 1'b0, 1'b1, 32);
    rx_expect_take("R12 after", 8'hE7, 1'b0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule